// File: doc/BRIEF.md
# Hold-Aware Interrupt Output Controller

This block drives an active-low interrupt-output pin that tells an external bus master that an interrupt is pending and the core needs the bus back. It also runs the hold handshake with that master. The master asks for the bus on an active-low hold input. The block grants the bus on an active-low acknowledge output. While it holds the bus, the block can ask for it back on an active-low bus-request output.

The moment the interrupt output is driven depends on three things: the handshake phase, whether the core is fetching code from on-chip or off-chip memory, and whether the interrupt arrived in the short window between the hold request and the grant. An interrupt request is a one-cycle pulse, and it stays pending in the block until an acknowledge pulse clears it. The hold input is asynchronous and passes through a two-flop synchronizer. An internal permit input tells the block whether the core may give up the bus at all.

Top module: `hirq_out_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the grant, bus-request and interrupt outputs are all high (inactive), and no grant is given until a hold request is seen.
- R2: With the permit high, a hold request first sampled low at rising edge k produces a grant (grant output low) at edge k+3. The grant is not visible before that edge.
- R3: While the permit is low, a hold request is never granted.
- R4: A hold request that goes away before it has been seen for two consecutive synchronized cycles produces no grant.
- R5: During a grant with on-chip code fetch (fetch flag 0), a pending interrupt drives the interrupt output low on the same edge that samples the request.
- R6: During a grant with off-chip code fetch (fetch flag 1), a pending interrupt drives the bus-request output low on the sampling edge. The interrupt output stays high for as long as the hold request stays low.
- R7: After a hold request is released (first sampled high at edge k), the grant goes high at edge k+2. If bus request was active, the bus request goes high and the interrupt output goes low on that same edge.
- R8: An interrupt that arrives with off-chip fetch after the hold request is seen but before the grant drives the grant and the interrupt output low on the same edge. The bus request is not driven.
- R9: In the R8 case, the interrupt output stays low until the hold request is released, even if the interrupt is acknowledged first. After the release it follows the pending state.
- R10: Outside the R9 case, an acknowledge pulse clears the pending interrupt, and the interrupt and bus-request outputs go high on the next edge. An acknowledge takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | One-cycle pulse: an interrupt became pending |
| irq_ack_i | input | 1 | One-cycle pulse: the pending interrupt was serviced |
| ext_fetch_i | input | 1 | 1 = code is fetched from off-chip memory, 0 = on-chip |
| hold_ok_i | input | 1 | Core permits giving up the bus |
| hold_req_n_i | input | 1 | Asynchronous active-low hold request from the external master |
| hold_ack_n_o | output | 1 | Active-low hold grant |
| bus_req_n_o | output | 1 | Active-low request to get the bus back |
| irq_out_n_o | output | 1 | Active-low interrupt output |

## Verification
The assertions check these rules on every cycle: a bus request is only driven during a grant, the race case never drives a bus request, the interrupt output stays high while the block waits for the bus to be released, a grant only follows the entering phase, and an acknowledge outside the race clears both outputs on the next edge. Only the bench scenarios show the exact latencies through the synchronizer. They also show that a short hold pulse or a low permit yields no grant, and that in the race case the interrupt output survives an acknowledge until the hold is released. A cycle-level reference model in the bench, under random stimulus, covers the ways these phases combine.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ENTER   = 2'd1,
        PH_HELD    = 2'd2,
        PH_RELEASE = 2'd3
    } hold_phase_e;

    typedef struct packed {
        hold_phase_e phase;
        logic        race;
        logic        grant;
        logic        breq;
        logic        irq_out;
    } hold_state_t;

    localparam hold_state_t HOLD_STATE_RST = '{
        phase:   PH_IDLE,
        race:    1'b0,
        grant:   1'b0,
        breq:    1'b0,
        irq_out: 1'b0
    };

endpackage

// File: rtl/hirq_sync.sv
module hirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
    } sync_state_t;

    sync_state_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                s_d.chain = async_i;
            end
        end else begin : g_multi
            always_comb begin
                s_d.chain = {s_q.chain[LAST-1:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.chain[LAST];

endmodule

// File: rtl/hirq_pend.sv
module hirq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    output logic pend_d_o,
    output logic pend_q_o
);
    typedef struct packed {
        logic pend;
    } pend_state_t;

    pend_state_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (ack_i) begin
            p_d.pend = 1'b0;
        end else if (req_i) begin
            p_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pend_d_o = p_d.pend;
    assign pend_q_o = p_q.pend;

    p_ack_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !pend_q_o);

endmodule

// File: rtl/hirq_fsm.sv
module hirq_fsm
    import hirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s_i,
    input  logic hold_ok_i,
    input  logic ext_fetch_i,
    input  logic pend_d_i,
    input  logic ack_i,
    output logic grant_o,
    output logic breq_o,
    output logic irq_out_o
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (hold_s_i && hold_ok_i) begin
                    st_d.phase = PH_ENTER;
                end
            end
            PH_ENTER: begin
                if (!hold_s_i) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase = PH_HELD;
                    st_d.race  = pend_d_i && ext_fetch_i;
                end
            end
            PH_HELD: begin
                if (!hold_s_i) begin
                    st_d.phase = PH_IDLE;
                end else if (pend_d_i && ext_fetch_i && !st_q.race && !st_q.irq_out) begin
                    st_d.phase = PH_RELEASE;
                end
            end
            PH_RELEASE: begin
                if (!hold_s_i) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        if (st_d.phase == PH_IDLE) begin
            st_d.race = 1'b0;
        end

        st_d.grant = (st_d.phase == PH_HELD) || (st_d.phase == PH_RELEASE);
        st_d.breq  = pend_d_i && (st_d.phase == PH_RELEASE);

        if (st_d.race) begin
            st_d.irq_out = 1'b1;
        end else if (!pend_d_i) begin
            st_d.irq_out = 1'b0;
        end else if (st_q.irq_out) begin
            st_d.irq_out = 1'b1;
        end else if (st_d.phase == PH_HELD && !ext_fetch_i) begin
            st_d.irq_out = 1'b1;
        end else if (st_q.phase == PH_RELEASE && st_d.phase == PH_IDLE) begin
            st_d.irq_out = 1'b1;
        end else begin
            st_d.irq_out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HOLD_STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o   = st_q.grant;
    assign breq_o    = st_q.breq;
    assign irq_out_o = st_q.irq_out;

    p_breq_in_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        breq_o |-> grant_o);

    p_wait_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RELEASE) |-> !irq_out_o);

    p_race_no_breq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.race |-> !breq_o);

    p_race_holds_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.race && hold_s_i) |=> irq_out_o);

    p_grant_from_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(st_q.phase == PH_ENTER));

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !st_q.race) |=> (!irq_out_o && !breq_o));

endmodule

// File: rtl/hirq_out_ctrl.sv
module hirq_out_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic irq_ack_i,
    input  logic ext_fetch_i,
    input  logic hold_ok_i,
    input  logic hold_req_n_i,
    output logic hold_ack_n_o,
    output logic bus_req_n_o,
    output logic irq_out_n_o
);
    logic hold_s;
    logic pend_d;
    logic pend_q;
    logic grant;
    logic breq;
    logic irq_out;

    hirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (!hold_req_n_i),
        .sync_o  (hold_s)
    );

    hirq_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (irq_req_i),
        .ack_i    (irq_ack_i),
        .pend_d_o (pend_d),
        .pend_q_o (pend_q)
    );

    hirq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_s_i    (hold_s),
        .hold_ok_i   (hold_ok_i),
        .ext_fetch_i (ext_fetch_i),
        .pend_d_i    (pend_d),
        .ack_i       (irq_ack_i),
        .grant_o     (grant),
        .breq_o      (breq),
        .irq_out_o   (irq_out)
    );

    assign hold_ack_n_o = !grant;
    assign bus_req_n_o  = !breq;
    assign irq_out_n_o  = !irq_out;

    p_irq_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out_n_o && hold_ack_n_o) |-> pend_q);

endmodule

// File: tb/hirq_out_ctrl_bench.sv
module hirq_out_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 1'b0, irq_ack = 1'b0, ext_fetch = 1'b0, hold_ok = 1'b1, hold_req_n = 1'b1;
    logic hold_ack_n, bus_req_n, irq_out_n;
    int   checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hirq_out_ctrl u_hirq_out_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_ack_i(irq_ack),
        .ext_fetch_i(ext_fetch), .hold_ok_i(hold_ok), .hold_req_n_i(hold_req_n),
        .hold_ack_n_o(hold_ack_n), .bus_req_n_o(bus_req_n), .irq_out_n_o(irq_out_n)
    );

    // Reference model, written from the requirements as a phase table
    int   m_ph;            // 0 idle, 1 seen, 2 granted, 3 waiting for release
    logic m_h1, m_h2, m_pend, m_race, m_grant, m_breq, m_irq;

    function automatic logic next_pend(logic p, logic rq, logic ak);
        return ak ? 1'b0 : (rq ? 1'b1 : p);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_h1 = 0; m_h2 = 0; m_pend = 0; m_race = 0;
            m_grant = 0; m_breq = 0; m_irq = 0;
        end else begin
            logic p; int nph; logic nrace, nirq, hs;
            hs = m_h2;
            p = next_pend(m_pend, irq_req, irq_ack);
            nph = m_ph; nrace = m_race;
            if (m_ph == 0 && hs && hold_ok) nph = 1;
            else if (m_ph != 0 && !hs) nph = 0;
            else if (m_ph == 1) begin nph = 2; nrace = p && ext_fetch; end
            else if (m_ph == 2 && p && ext_fetch && !m_race && !m_irq) nph = 3;
            if (nph == 0) nrace = 0;
            if (nrace) nirq = 1;
            else if (!p) nirq = 0;
            else if (m_irq) nirq = 1;
            else if (nph == 2 && !ext_fetch) nirq = 1;
            else if (m_ph == 3 && nph == 0) nirq = 1;
            else nirq = 0;
            m_grant = (nph >= 2);
            m_breq = p && (nph == 3);
            m_irq = nirq; m_race = nrace; m_ph = nph; m_pend = p;
            m_h2 = m_h1; m_h1 = !hold_req_n;
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic model_cmp();
        chk("R2", hold_ack_n, !m_grant, "model grant");
        chk("R6", bus_req_n, !m_breq, "model bus request");
        chk("R5", irq_out_n, !m_irq, "model interrupt out");
    endtask

    task automatic do_reset();
        rst_n = 0; irq_req = 0; irq_ack = 0; hold_req_n = 1; hold_ok = 1; ext_fetch = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic pulse_req();
        irq_req = 1; tick(1); irq_req = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; tick(1); irq_ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        chk("R1", hold_ack_n, 1'b1, "grant in reset");
        chk("R1", bus_req_n, 1'b1, "breq in reset");
        chk("R1", irq_out_n, 1'b1, "irq in reset");
        do_reset();
        tick(3);
        chk("R1", hold_ack_n, 1'b1, "no grant after reset");

        // R2 grant latency, R5 on-chip fetch, R10 ack
        hold_req_n = 0;
        tick(3);
        chk("R2", hold_ack_n, 1'b1, "grant too early");
        tick(1);
        chk("R2", hold_ack_n, 1'b0, "grant at fourth edge");
        irq_req = 1; irq_ack = 1; tick(1); irq_req = 0; irq_ack = 0;
        chk("R10", irq_out_n, 1'b1, "ack beats same-cycle request");
        pulse_req();
        chk("R5", irq_out_n, 1'b0, "on-chip irq immediate");
        chk("R5", bus_req_n, 1'b1, "no breq on-chip");
        pulse_ack();
        chk("R10", irq_out_n, 1'b1, "ack clears irq");
        hold_req_n = 1;
        tick(2);
        chk("R7", hold_ack_n, 1'b0, "grant kept before sync");
        tick(1);
        chk("R7", hold_ack_n, 1'b1, "grant released");

        // R6 / R7 off-chip fetch
        ext_fetch = 1; hold_req_n = 0;
        tick(4);
        pulse_req();
        chk("R6", bus_req_n, 1'b0, "breq asserted");
        chk("R6", irq_out_n, 1'b1, "irq held off");
        tick(5);
        chk("R6", irq_out_n, 1'b1, "irq still held off");
        hold_req_n = 1;
        tick(3);
        chk("R7", hold_ack_n, 1'b1, "grant released");
        chk("R7", bus_req_n, 1'b1, "breq released");
        chk("R7", irq_out_n, 1'b0, "irq after release");
        pulse_ack();
        chk("R10", irq_out_n, 1'b1, "ack clears irq");

        // R8 / R9 race window
        hold_req_n = 0;
        tick(3);
        pulse_req();
        chk("R8", hold_ack_n, 1'b0, "race grant");
        chk("R8", irq_out_n, 1'b0, "race irq with grant");
        chk("R8", bus_req_n, 1'b1, "race no breq");
        pulse_ack();
        tick(3);
        chk("R9", irq_out_n, 1'b0, "race irq survives ack");
        hold_req_n = 1;
        tick(3);
        chk("R9", hold_ack_n, 1'b1, "race grant released");
        chk("R9", irq_out_n, 1'b1, "race irq released");

        // R3 permit low
        hold_ok = 0; hold_req_n = 0;
        tick(8);
        chk("R3", hold_ack_n, 1'b1, "no grant without permit");
        hold_req_n = 1; hold_ok = 1;
        tick(4);

        // R4 short hold pulse
        hold_req_n = 0; tick(1); hold_req_n = 1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            chk("R4", hold_ack_n, 1'b1, "short pulse no grant");
        end

        // Random phase against the reference model
        do_reset();
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            model_cmp();
            irq_req = ($urandom % 8) == 0;
            irq_ack = ($urandom % 14) == 0;
            if (($urandom % 30) == 0) ext_fetch = ~ext_fetch;
            if (($urandom % 12) == 0) hold_req_n = ~hold_req_n;
            if (($urandom % 25) == 0) hold_ok = ~hold_ok;
            tick(1);
        end
        model_cmp();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule